// File: doc/BRIEF.md
# Transaction-Counted Burst Sequencer

This block moves data in bursts over a 16-bit parallel bus between an endpoint buffer of a USB controller and an attached FPGA. Software first writes a 32-bit transaction count, one byte at a time. It then issues a trigger that names an endpoint and a direction. The sequencer runs one transfer per clock until its working counter expires, then returns to idle. It raises an idle flag, and software polls that flag before it issues the next trigger.

A trigger is taken only when the sequencer is idle, the count is non-zero and both ends of the path can take part. For a write toward the FPGA, the source buffer must hold data and the FPGA must report room for a packet. For a read from the FPGA, the destination buffer must have space and the FPGA must report a packet ready. In word mode each transaction carries a full 16-bit word. In byte mode only the low byte carries data and the upper byte reads zero. A count of 256 gives the usual 512-byte high-speed packet, and a count of 32 gives the 64-byte full-speed packet.

Top module: `bseq_burst_top`

## Requirements
- R1: After reset, `idle` is 1 and `wr_strobe`, `rd_strobe`, `ep_pop`, `ep_push` and `bus_oe` are all 0.
- R2: A write with `cnt_wr_en`=1 and `cnt_wr_sel`=i loads `cnt_wr_byte` into bits [8i+7:8i] of the 32-bit transaction count. The other three bytes keep their values.
- R3: When a trigger is taken at a clock edge, `idle` is 0 and a transfer strobe is 1 in the following cycle. The strobe stays 1 for exactly N consecutive cycles, where N is the loaded count. `idle` returns to 1 in the cycle after the last transfer.
- R4: A write trigger (`trig_dir`=0) is ignored while `ep_empty`=1 or `fpga_room`=0. `idle` stays 1 and no strobe occurs.
- R5: A read trigger (`trig_dir`=1) is ignored while `ep_full`=1 or `fpga_pkt_avail`=0.
- R6: A trigger that arrives while the sequencer is busy is ignored. The running burst keeps its length, its direction and its endpoint.
- R7: A trigger with a loaded count of zero produces no transfer cycles, and `idle` stays 1.
- R8: During a write burst, `wr_strobe`, `ep_pop` and `bus_oe` are 1 in every transfer cycle and `rd_strobe` is 0. `bus_dout` equals `ep_rd_data` in word mode and `{8'h00, ep_rd_data[7:0]}` in byte mode. `bus_oe` is 0 outside write bursts.
- R9: During a read burst, `rd_strobe` and `ep_push` are 1 in every transfer cycle and `bus_oe` stays 0. `ep_wr_data` equals `bus_din` in word mode and `{8'h00, bus_din[7:0]}` in byte mode.
- R10: Throughout a burst, `active_ep` shows the endpoint carried by the trigger that was taken.
- R11: The loaded count is kept after a burst, so a second trigger without a reload repeats the same length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_wr_en | input | 1 | Write one byte of the transaction count |
| cnt_wr_sel | input | 2 | Byte index of the count write |
| cnt_wr_byte | input | 8 | Byte value to load |
| trig_valid | input | 1 | Trigger request |
| trig_ep | input | 2 | Endpoint selected by the trigger |
| trig_dir | input | 1 | 0 = write to FPGA, 1 = read from FPGA |
| trig_word | input | 1 | 1 = 16-bit transactions, 0 = byte transactions |
| ep_empty | input | 1 | Source endpoint buffer is empty |
| ep_full | input | 1 | Destination endpoint buffer is full |
| fpga_room | input | 1 | FPGA can accept a packet |
| fpga_pkt_avail | input | 1 | FPGA has a packet ready |
| ep_rd_data | input | 16 | Data presented by the endpoint buffer |
| bus_din | input | 16 | Parallel bus data from the FPGA |
| idle | output | 1 | Sequencer is idle and will accept a trigger |
| active_ep | output | 2 | Endpoint of the current burst |
| wr_strobe | output | 1 | Write strobe toward the FPGA, one per transfer |
| rd_strobe | output | 1 | Read strobe toward the FPGA, one per transfer |
| bus_oe | output | 1 | Output enable for the parallel bus |
| bus_dout | output | 16 | Data driven toward the FPGA |
| ep_pop | output | 1 | Consume one entry from the endpoint buffer |
| ep_push | output | 1 | Store one entry into the endpoint buffer |
| ep_wr_data | output | 16 | Data written into the endpoint buffer |

## Verification
The bench sweeps every burst length from 1 to 40 in both directions and both widths. It also runs the 32 and 256 packet sizes and a count of 65536. That count needs a byte other than the lowest, so a design that stored count bytes at the wrong position, or that ended on zero instead of one, would give a burst that is too long or too short. Triggers are sent while busy, with a zero count, and with each gating flag against the transfer. A design that took any of these would start a stray burst or change the endpoint or direction of the running one. In byte mode the bench checks that the upper data byte is zero in both directions. A missing mask would leak upper bits onto the bus.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  typedef enum logic {
    DIR_WRITE = 1'b0,
    DIR_READ  = 1'b1
  } dir_e;
endpackage

// File: rtl/bseq_count_reg.sv
module bseq_count_reg #(
  parameter int NBYTES = 4,
  localparam int SEL_W = (NBYTES > 1) ? $clog2(NBYTES) : 1,
  localparam int CNT_W = 8 * NBYTES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [7:0]       wr_byte,
  output logic [CNT_W-1:0] count
);
  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)
        count[8*i +: 8] <= 8'h00;
      else if (wr_en && wr_sel == SEL_W'(i))
        count[8*i +: 8] <= wr_byte;
    end
  end
endmodule

// File: rtl/bseq_fsm.sv
module bseq_fsm
  import bseq_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int EP_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_valid,
  input  logic [EP_W-1:0]  trig_ep,
  input  dir_e             trig_dir,
  input  logic             trig_word,
  input  logic             ep_empty,
  input  logic             ep_full,
  input  logic             fpga_room,
  input  logic             fpga_pkt_avail,
  input  logic [CNT_W-1:0] load_count,
  output logic             idle_q,
  output logic             xfer_q,
  output dir_e             dir_q,
  output logic             word_q,
  output logic [EP_W-1:0]  ep_q
);
  logic [CNT_W-1:0] remaining_q;
  logic             gate_ok;
  logic             accept;
  logic             expired;

  always_comb begin
    if (trig_dir == DIR_WRITE)
      gate_ok = !ep_empty && fpga_room;
    else
      gate_ok = !ep_full && fpga_pkt_avail;
  end

  assign accept  = idle_q && trig_valid && gate_ok && (load_count != '0);
  assign expired = (remaining_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_q      <= 1'b1;
      xfer_q      <= 1'b0;
      remaining_q <= '0;
      dir_q       <= DIR_WRITE;
      word_q      <= 1'b0;
      ep_q        <= '0;
    end else if (accept) begin
      idle_q      <= 1'b0;
      xfer_q      <= 1'b1;
      remaining_q <= load_count;
      dir_q       <= trig_dir;
      word_q      <= trig_word;
      ep_q        <= trig_ep;
    end else if (xfer_q) begin
      remaining_q <= remaining_q - CNT_W'(1);
      if (expired) begin
        xfer_q <= 1'b0;
        idle_q <= 1'b1;
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    idle_q |-> !xfer_q); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (xfer_q && !expired) |=> (remaining_q == $past(remaining_q) - CNT_W'(1))); // R3
  AST_LAST_XFER: assert property (@(posedge clk) disable iff (rst)
    (xfer_q && expired) |=> idle_q); // R3
  AST_WR_GATE: assert property (@(posedge clk) disable iff (rst)
    (idle_q && trig_valid && trig_dir == DIR_WRITE && (ep_empty || !fpga_room)) |=> idle_q); // R4
  AST_RD_GATE: assert property (@(posedge clk) disable iff (rst)
    (idle_q && trig_valid && trig_dir == DIR_READ && (ep_full || !fpga_pkt_avail)) |=> idle_q); // R5
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!idle_q && trig_valid) |=> ($stable(dir_q) && $stable(ep_q) && $stable(word_q))); // R6
  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (rst)
    (idle_q && trig_valid && load_count == '0) |=> idle_q); // R7
endmodule

// File: rtl/bseq_datapath.sv
module bseq_datapath
  import bseq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xfer,
  input  dir_e              dir,
  input  logic              word,
  input  logic [DATA_W-1:0] ep_rd_data,
  input  logic [DATA_W-1:0] bus_din,
  output logic              wr_strobe,
  output logic              rd_strobe,
  output logic              bus_oe,
  output logic [DATA_W-1:0] bus_dout,
  output logic              ep_pop,
  output logic              ep_push,
  output logic [DATA_W-1:0] ep_wr_data
);
  localparam int BYTE_W = 8;
  logic [DATA_W-1:0] lane_mask;

  if (DATA_W > BYTE_W) begin : g_wide
    assign lane_mask = word ? {DATA_W{1'b1}} : {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
  end else begin : g_narrow
    assign lane_mask = {DATA_W{1'b1}};
  end

  assign wr_strobe  = xfer && (dir == DIR_WRITE);
  assign rd_strobe  = xfer && (dir == DIR_READ);
  assign ep_pop     = wr_strobe;
  assign ep_push    = rd_strobe;
  assign bus_oe     = wr_strobe;
  assign bus_dout   = bus_oe ? (ep_rd_data & lane_mask) : '0;
  assign ep_wr_data = rd_strobe ? (bus_din & lane_mask) : '0;

  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (rst)
    !(wr_strobe && rd_strobe)); // R8
endmodule

// File: rtl/bseq_burst_top.sv
module bseq_burst_top
  import bseq_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int CNT_BYTES = 4,
  parameter int EP_W      = 2,
  localparam int SEL_W    = (CNT_BYTES > 1) ? $clog2(CNT_BYTES) : 1,
  localparam int CNT_W    = 8 * CNT_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_wr_en,
  input  logic [SEL_W-1:0]  cnt_wr_sel,
  input  logic [7:0]        cnt_wr_byte,
  input  logic              trig_valid,
  input  logic [EP_W-1:0]   trig_ep,
  input  logic              trig_dir,
  input  logic              trig_word,
  input  logic              ep_empty,
  input  logic              ep_full,
  input  logic              fpga_room,
  input  logic              fpga_pkt_avail,
  input  logic [DATA_W-1:0] ep_rd_data,
  input  logic [DATA_W-1:0] bus_din,
  output logic              idle,
  output logic [EP_W-1:0]   active_ep,
  output logic              wr_strobe,
  output logic              rd_strobe,
  output logic              bus_oe,
  output logic [DATA_W-1:0] bus_dout,
  output logic              ep_pop,
  output logic              ep_push,
  output logic [DATA_W-1:0] ep_wr_data
);
  logic [CNT_W-1:0] count;
  logic             xfer;
  dir_e             dir_cur;
  dir_e             trig_dir_e;
  logic             word_cur;

  assign trig_dir_e = dir_e'(trig_dir);

  bseq_count_reg #(.NBYTES(CNT_BYTES)) u_count (
    .clk(clk), .rst(rst), .wr_en(cnt_wr_en), .wr_sel(cnt_wr_sel),
    .wr_byte(cnt_wr_byte), .count(count)
  );

  bseq_fsm #(.CNT_W(CNT_W), .EP_W(EP_W)) u_fsm (
    .clk(clk), .rst(rst), .trig_valid(trig_valid), .trig_ep(trig_ep),
    .trig_dir(trig_dir_e), .trig_word(trig_word), .ep_empty(ep_empty),
    .ep_full(ep_full), .fpga_room(fpga_room), .fpga_pkt_avail(fpga_pkt_avail),
    .load_count(count), .idle_q(idle), .xfer_q(xfer), .dir_q(dir_cur),
    .word_q(word_cur), .ep_q(active_ep)
  );

  bseq_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .xfer(xfer), .dir(dir_cur), .word(word_cur),
    .ep_rd_data(ep_rd_data), .bus_din(bus_din), .wr_strobe(wr_strobe),
    .rd_strobe(rd_strobe), .bus_oe(bus_oe), .bus_dout(bus_dout),
    .ep_pop(ep_pop), .ep_push(ep_push), .ep_wr_data(ep_wr_data)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> (idle && !wr_strobe && !rd_strobe)); // R1
  AST_OE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> !idle); // R8
endmodule

// File: tb/bseq_burst_top_tb_top.sv
module bseq_burst_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_wr_en = 1'b0;
  logic [1:0]  cnt_wr_sel = 2'd0;
  logic [7:0]  cnt_wr_byte = 8'd0;
  logic        trig_valid = 1'b0;
  logic [1:0]  trig_ep = 2'd0;
  logic        trig_dir = 1'b0;
  logic        trig_word = 1'b0;
  logic        ep_empty = 1'b0;
  logic        ep_full = 1'b0;
  logic        fpga_room = 1'b1;
  logic        fpga_pkt_avail = 1'b1;
  logic [15:0] ep_rd_data = 16'h0;
  logic [15:0] bus_din = 16'h0;
  logic        idle, wr_strobe, rd_strobe, bus_oe, ep_pop, ep_push;
  logic [1:0]  active_ep;
  logic [15:0] bus_dout, ep_wr_data;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  bseq_burst_top dut_i (
    .clk(clk), .rst(rst), .cnt_wr_en(cnt_wr_en), .cnt_wr_sel(cnt_wr_sel),
    .cnt_wr_byte(cnt_wr_byte), .trig_valid(trig_valid), .trig_ep(trig_ep),
    .trig_dir(trig_dir), .trig_word(trig_word), .ep_empty(ep_empty),
    .ep_full(ep_full), .fpga_room(fpga_room), .fpga_pkt_avail(fpga_pkt_avail),
    .ep_rd_data(ep_rd_data), .bus_din(bus_din), .idle(idle),
    .active_ep(active_ep), .wr_strobe(wr_strobe), .rd_strobe(rd_strobe),
    .bus_oe(bus_oe), .bus_dout(bus_dout), .ep_pop(ep_pop), .ep_push(ep_push),
    .ep_wr_data(ep_wr_data)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      finish_run();
    end
  end

  task automatic write_byte(input int sel, input logic [7:0] b);
    @(negedge clk);
    cnt_wr_en = 1'b1; cnt_wr_sel = 2'(sel); cnt_wr_byte = b;
    @(negedge clk);
    cnt_wr_en = 1'b0;
  endtask

  task automatic load_count(input logic [31:0] v);
    for (int i = 0; i < 4; i++) write_byte(i, v[8*i +: 8]);
  endtask

  task automatic pulse_trig(input bit dir, input logic [1:0] ep, input bit word);
    @(negedge clk);
    trig_valid = 1'b1; trig_dir = dir; trig_ep = ep; trig_word = word;
    @(negedge clk);
    trig_valid = 1'b0;
  endtask

  // Runs a burst expected to last exp_n cycles; checks length, strobes, data, endpoint.
  task automatic run_burst(input bit dir, input logic [1:0] ep, input bit word,
                           input int exp_n, input string req);
    int n = 0;
    int derr = 0;
    logic [15:0] mask;
    mask = word ? 16'hFFFF : 16'h00FF;
    pulse_trig(dir, ep, word);
    while (!idle && n < exp_n + 8) begin
      if (dir == 1'b0) begin
        if (!(wr_strobe && ep_pop && bus_oe && !rd_strobe && !ep_push)) derr++;
        if (bus_dout !== (ep_rd_data & mask)) derr++;
      end else begin
        if (!(rd_strobe && ep_push && !wr_strobe && !ep_pop && !bus_oe)) derr++;
        if (ep_wr_data !== (bus_din & mask)) derr++;
      end
      if (active_ep !== ep) derr++;
      n++;
      ep_rd_data = 16'hA53C ^ 16'(n * 16'h0137);
      bus_din    = 16'h5AC3 ^ 16'(n * 16'h0B09);
      @(negedge clk);
    end
    check(n == exp_n, {req, " R3 burst length"}, n, exp_n);
    check(derr == 0, {req, dir ? " R9 R10 read strobes/data" : " R8 R10 write strobes/data"}, derr, 0);
    check(idle && !wr_strobe && !rd_strobe && !bus_oe, {req, " R3 idle after burst"}, idle, 1);
  endtask

  task automatic expect_ignored(input bit dir, input string req);
    int seen = 0;
    pulse_trig(dir, 2'd1, 1'b1);
    for (int k = 0; k < 4; k++) begin
      if (!idle || wr_strobe || rd_strobe || bus_oe) seen++;
      @(negedge clk);
    end
    check(seen == 0, req, seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(idle && !wr_strobe && !rd_strobe && !ep_pop && !ep_push && !bus_oe,
          "R1 reset state", idle, 1);
    rst = 1'b0;
    @(negedge clk);
    check(idle === 1'b1, "R1 idle after reset release", idle, 1);

    // R7: count zero after reset
    expect_ignored(1'b0, "R7 zero count write");
    expect_ignored(1'b1, "R7 zero count read");

    // Sweep lengths, directions, widths
    for (int n = 1; n <= 40; n++) begin
      load_count(32'(n));
      for (int d = 0; d < 2; d++)
        for (int w = 0; w < 2; w++)
          run_burst(d[0], 2'(n + d), w[0], n, "sweep");
    end

    // Packet sizes
    load_count(32'd32);
    run_burst(1'b0, 2'd2, 1'b1, 32, "R3 full-speed packet");
    load_count(32'd256);
    run_burst(1'b1, 2'd3, 1'b1, 256, "R3 high-speed packet");

    // R2: byte lanes, partial rewrite
    load_count(32'h0000_0105);
    run_burst(1'b0, 2'd0, 1'b0, 261, "R2 byte1 lane");
    write_byte(0, 8'h03);
    run_burst(1'b1, 2'd1, 1'b1, 259, "R2 partial rewrite");
    // R11: reuse without reload
    run_burst(1'b0, 2'd2, 1'b1, 259, "R11 repeat count");
    load_count(32'h0001_0000);
    run_burst(1'b1, 2'd3, 1'b0, 65536, "R2 byte2 lane");

    // Gating
    load_count(32'd10);
    ep_empty = 1'b1;
    expect_ignored(1'b0, "R4 write with empty buffer");
    ep_empty = 1'b0; fpga_room = 1'b0;
    expect_ignored(1'b0, "R4 write with no FPGA room");
    run_burst(1'b1, 2'd2, 1'b1, 10, "R4 read unaffected by room flag");
    fpga_room = 1'b1; ep_full = 1'b1;
    expect_ignored(1'b1, "R5 read with full buffer");
    run_burst(1'b0, 2'd1, 1'b0, 10, "R5 write unaffected by full flag");
    ep_full = 1'b0; fpga_pkt_avail = 1'b0;
    expect_ignored(1'b1, "R5 read with no FPGA packet");
    fpga_pkt_avail = 1'b1;

    // R6: trigger while busy
    begin
      int n = 0;
      int bad = 0;
      load_count(32'd20);
      pulse_trig(1'b0, 2'd1, 1'b1);
      while (!idle && n < 40) begin
        if (n == 5) begin trig_valid = 1'b1; trig_dir = 1'b1; trig_ep = 2'd3; end
        else trig_valid = 1'b0;
        if (!wr_strobe || rd_strobe || active_ep !== 2'd1) bad++;
        n++;
        @(negedge clk);
      end
      trig_valid = 1'b0;
      check(n == 20, "R6 busy trigger length", n, 20);
      check(bad == 0, "R6 busy trigger dir/ep", bad, 0);
      // R7 zero count with nonzero history
      load_count(32'd0);
      expect_ignored(1'b0, "R7 zero count after bursts");
    end

    finish_run();
  end
endmodule